// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the general registers of a 64-bit integer core: thirty-one writable 64-bit registers, plus a constant-zero register at the top index, reached through one synchronous write port and two combinational read ports. Alongside the main storage sits a small bank of eight extra registers. These extra registers stand in for a fixed, non-contiguous subset of register numbers, but only while the core runs its privileged firmware.

A single mode input selects the view. When the mode input is high, register numbers 8 to 14 and register number 25 are redirected to the eight bank slots. In all other cases, and for every other number, the main storage is used. The redirection is worked out separately for the write port and for each read port, from the mode value present in that same cycle. Firmware can therefore use scratch registers without saving the interrupted program's values. Every port shares the same decode, so the lookup costs no extra cycle.

Top module: `bankreg_file`

## Requirements
- R1: With `fw_mode` low, every register number 0 to 30 reads and writes the main storage, including numbers 8 to 14 and 25.
- R2: With `fw_mode` high, register numbers 8, 9, 10, 11, 12, 13 and 14 read and write bank slots 0 through 6 in that order.
- R3: With `fw_mode` high, register number 25 reads and writes bank slot 7.
- R4: A write to a redirected number leaves the other view's copy of that number unchanged: a write made in firmware mode is not visible in normal mode, and the reverse also holds.
- R5: Register number 31 always reads as zero on both ports, and a write to it has no effect.
- R6: A write takes effect at the rising clock edge when `wr_en` is high. A read of the same register in the same cycle returns the value held before that write.
- R7: Routing follows the value of `fw_mode` in the current cycle. Toggling it between cycles switches a read of a redirected number between the two copies with no delay.
- R8: A cycle with synchronous `rst` high clears all main registers and all bank slots to zero and ignores any write in that cycle.
- R9: The two read ports work independently and can return different registers in the same cycle.
- R10: Register numbers outside 8 to 14 and 25 refer to the same storage in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fw_mode | input | 1 | High while the core runs privileged firmware |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 5 | Register number to write |
| wr_data | input | 64 | Value to write |
| rd_a_idx | input | 5 | Register number for read port A |
| rd_a_data | output | 64 | Read port A value (combinational) |
| rd_b_idx | input | 5 | Register number for read port B |
| rd_b_data | output | 64 | Read port B value (combinational) |

## Verification
Read results are due in the same cycle as their index and mode, with no register in between. Written values appear one edge later. The bench drives all inputs just after a falling edge and samples both read ports 1 ns later, still inside the low phase. At that point it compares them with a reference model that has not yet applied the pending write. It applies that write to the model only after the following rising edge. This order makes same-cycle read-before-write and same-cycle mode changes come out exactly as the requirements state.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;
    localparam int XLEN         = 64;
    localparam int NREGS        = 32;
    localparam int SHADOW_DEPTH = 8;
    localparam int SHADOW_BASE  = 8;   // first register number of the contiguous run
    localparam int SHADOW_RUN   = 7;   // length of the contiguous run
    localparam int SHADOW_ALT   = 25;  // stray register number taking the last slot
    localparam int IDX_W        = $clog2(NREGS);
    localparam int SLOT_W       = $clog2(SHADOW_DEPTH);

    typedef struct packed {
        logic              hit;
        logic [SLOT_W-1:0] slot;
    } route_t;
endpackage

// File: rtl/bankreg_map.sv
module bankreg_map
    import bankreg_pkg::*;
(
    input  logic             fw_mode,
    input  logic [IDX_W-1:0] idx,
    output route_t           route
);
    localparam logic [IDX_W-1:0]  BASE  = IDX_W'(SHADOW_BASE);
    localparam logic [IDX_W-1:0]  LAST  = IDX_W'(SHADOW_BASE + SHADOW_RUN - 1);
    localparam logic [IDX_W-1:0]  ALT   = IDX_W'(SHADOW_ALT);
    localparam logic [SLOT_W-1:0] ALT_S = SLOT_W'(SHADOW_RUN);

    logic             in_run;
    logic             is_alt;
    logic [IDX_W-1:0] offset;

    always_comb begin
        in_run     = (idx >= BASE) && (idx <= LAST);
        is_alt     = (idx == ALT);
        offset     = idx - BASE;
        route.hit  = fw_mode && (in_run || is_alt);
        route.slot = is_alt ? ALT_S : offset[SLOT_W-1:0];
    end
endmodule

// File: rtl/bankreg_array.sv
module bankreg_array #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr0,
    output logic [WIDTH-1:0] rdata0,
    input  logic [AW-1:0]    raddr1,
    output logic [WIDTH-1:0] rdata1
);
    localparam logic [AW:0] LIMIT = (AW+1)'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we && ({1'b0, waddr} < LIMIT)) begin
            mem[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata0 = ({1'b0, raddr0} < LIMIT) ? mem[raddr0] : '0;
        rdata1 = ({1'b0, raddr1} < LIMIT) ? mem[raddr1] : '0;
    end
endmodule

// File: rtl/bankreg_file.sv
module bankreg_file
    import bankreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fw_mode,
    input  logic             wr_en,
    input  logic [4:0]       wr_idx,
    input  logic [63:0]      wr_data,
    input  logic [4:0]       rd_a_idx,
    output logic [63:0]      rd_a_data,
    input  logic [4:0]       rd_b_idx,
    output logic [63:0]      rd_b_data
);
    localparam logic [IDX_W-1:0] ZERO_IDX = IDX_W'(NREGS - 1);
    localparam int               MAIN_D   = NREGS - 1;

    route_t    w_rt, a_rt, b_rt;
    logic      main_we, shad_we;
    logic [XLEN-1:0] main_a, main_b, shad_a, shad_b;

    bankreg_map i_map_w (.fw_mode(fw_mode), .idx(wr_idx),   .route(w_rt));
    bankreg_map i_map_a (.fw_mode(fw_mode), .idx(rd_a_idx), .route(a_rt));
    bankreg_map i_map_b (.fw_mode(fw_mode), .idx(rd_b_idx), .route(b_rt));

    always_comb begin
        shad_we = wr_en && w_rt.hit;
        main_we = wr_en && !w_rt.hit && (wr_idx != ZERO_IDX);
    end

    bankreg_array #(.DEPTH(MAIN_D), .WIDTH(XLEN), .AW(IDX_W)) i_main (
        .clk(clk), .rst(rst), .we(main_we), .waddr(wr_idx), .wdata(wr_data),
        .raddr0(rd_a_idx), .rdata0(main_a),
        .raddr1(rd_b_idx), .rdata1(main_b)
    );

    bankreg_array #(.DEPTH(SHADOW_DEPTH), .WIDTH(XLEN), .AW(SLOT_W)) i_shad (
        .clk(clk), .rst(rst), .we(shad_we), .waddr(w_rt.slot), .wdata(wr_data),
        .raddr0(a_rt.slot), .rdata0(shad_a),
        .raddr1(b_rt.slot), .rdata1(shad_b)
    );

    always_comb begin
        if (a_rt.hit)                  rd_a_data = shad_a;
        else if (rd_a_idx == ZERO_IDX) rd_a_data = '0;
        else                           rd_a_data = main_a;
        if (b_rt.hit)                  rd_b_data = shad_b;
        else if (rd_b_idx == ZERO_IDX) rd_b_data = '0;
        else                           rd_b_data = main_b;
    end
endmodule

// File: rtl/bankreg_file_chk.sv
module bankreg_file_chk (
    input logic        clk,
    input logic        rst,
    input logic        fw_mode,
    input logic        wr_en,
    input logic [4:0]  wr_idx,
    input logic [63:0] wr_data,
    input logic [4:0]  rd_a_idx,
    input logic [63:0] rd_a_data,
    input logic [4:0]  rd_b_idx,
    input logic [63:0] rd_b_data
);
    AST_ZERO_REG_A: assert property (@(posedge clk) disable iff (rst)
        rd_a_idx == 5'd31 |-> rd_a_data == 64'd0); // R5
    AST_ZERO_REG_B: assert property (@(posedge clk) disable iff (rst)
        rd_b_idx == 5'd31 |-> rd_b_data == 64'd0); // R5
    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_a_data == 64'd0 && rd_b_data == 64'd0)); // R8
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en) && $past(wr_idx) != 5'd31
         && rd_a_idx == $past(wr_idx) && fw_mode == $past(fw_mode))
        |-> rd_a_data == $past(wr_data)); // R6
    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_en) && $stable(rd_b_idx) && $stable(fw_mode))
        |-> $stable(rd_b_data)); // R6
endmodule

bind bankreg_file bankreg_file_chk i_chk (
    .clk(clk), .rst(rst), .fw_mode(fw_mode), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data)
);

// File: tb/test_bankreg_file.sv
`timescale 1ns/1ps
module test_bankreg_file;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fw_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic [4:0]  rd_a_idx = '0;
    logic [63:0] rd_a_data;
    logic [4:0]  rd_b_idx = '0;
    logic [63:0] rd_b_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [63:0] m_main [31];
    logic [63:0] m_shad [8];

    always #2.5 clk = ~clk;

    bankreg_file i_bankreg_file (
        .clk(clk), .rst(rst), .fw_mode(fw_mode), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data)
    );

    function automatic int slot_of(int idx, bit fw);
        if (!fw) return -1;
        if (idx >= 8 && idx <= 14) return idx - 8;
        if (idx == 25) return 7;
        return -1;
    endfunction

    function automatic logic [63:0] mread(int idx, bit fw);
        int s = slot_of(idx, fw);
        if (s >= 0) return m_shad[s];
        if (idx == 31) return 64'd0;
        return m_main[idx];
    endfunction

    function automatic string auto_tag(int idx, bit fw);
        if (idx == 31) return "R5";
        if (fw && idx == 25) return "R3";
        if (slot_of(idx, fw) >= 0) return "R2";
        return "R1";
    endfunction

    task automatic mclear();
        for (int i = 0; i < 31; i++) m_main[i] = '0;
        for (int i = 0; i < 8; i++) m_shad[i] = '0;
    endtask

    task automatic mwrite(int idx, bit fw, logic [63:0] d);
        int s = slot_of(idx, fw);
        if (s >= 0) m_shad[s] = d;
        else if (idx != 31) m_main[idx] = d;
    endtask

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(bit we, int widx, logic [63:0] wd, bit fw,
                       int ra, int rb, string tag);
        @(negedge clk);
        wr_en = we; wr_idx = 5'(widx); wr_data = wd; fw_mode = fw;
        rd_a_idx = 5'(ra); rd_b_idx = 5'(rb);
        #1;
        chk(tag == "" ? auto_tag(ra, fw) : tag, rd_a_data, mread(ra, fw));
        chk(tag == "" ? auto_tag(rb, fw) : tag, rd_b_data, mread(rb, fw));
        @(posedge clk);
        if (we) mwrite(widx, fw, wd);
    endtask

    task automatic do_reset(bit write_too);
        @(negedge clk);
        rst = 1'b1; wr_en = write_too; wr_idx = 5'd3; wr_data = 64'hDEAD; fw_mode = 1'b0;
        @(posedge clk);
        mclear();
        @(negedge clk);
        rst = 1'b0; wr_en = 1'b0;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        mclear();
        do_reset(1'b0);
        // fill both banks, then reset with a write pending: R8
        for (int i = 0; i < 32; i++) cyc(1, i, {32'hA5A5_0000, 32'(i)}, i[0], 0, 1, "");
        do_reset(1'b1);
        for (int i = 0; i < 32; i++) begin
            cyc(0, 0, 0, 0, i, 31 - i, "R8");
            cyc(0, 0, 0, 1, i, 31 - i, "R8");
        end
        // R2 / R4: firmware write to 9 hides normal copy
        cyc(1, 9, 64'h1111, 0, 9, 9, "R1");
        cyc(1, 9, 64'h2222, 1, 9, 9, "R2");
        cyc(0, 0, 0, 0, 9, 9, "R4");
        cyc(0, 0, 0, 1, 9, 9, "R4");
        // R3: register 25
        cyc(1, 25, 64'h2525, 1, 25, 14, "R3");
        cyc(0, 0, 0, 1, 25, 8, "R3");
        cyc(0, 0, 0, 0, 25, 25, "R4");
        // R5: writes to 31 discarded
        cyc(1, 31, 64'hFFFF_FFFF_FFFF_FFFF, 0, 31, 31, "R5");
        cyc(1, 31, 64'h1234, 1, 31, 31, "R5");
        cyc(0, 0, 0, 0, 31, 30, "R5");
        // R6: same-cycle read returns old value
        cyc(1, 3, 64'hAAAA, 0, 3, 3, "R6");
        cyc(1, 3, 64'hBBBB, 0, 3, 3, "R6");
        cyc(0, 0, 0, 0, 3, 3, "R6");
        // R10: unmapped register shared across modes
        cyc(1, 5, 64'h5050, 1, 5, 15, "R10");
        cyc(0, 0, 0, 0, 5, 24, "R10");
        // R7: mode toggled every cycle on a redirected number
        cyc(1, 10, 64'h0A0A, 1, 0, 0, "R7");
        for (int i = 0; i < 6; i++) cyc(0, 0, 0, i[0], 10, 12, "R7");
        // R9: ports read different registers
        cyc(1, 7, 64'h7777, 0, 0, 0, "R9");
        cyc(0, 0, 0, 0, 7, 5, "R9");
        // constrained random
        for (int n = 0; n < 3000; n++) begin
            int wi = ($urandom % 4 == 0) ? (($urandom % 2) ? 25 : 8 + int'($urandom % 7))
                                         : int'($urandom % 32);
            cyc(bit'($urandom % 2), wi, {$urandom, $urandom}, bit'($urandom % 2),
                int'($urandom % 32), int'($urandom % 32), "");
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule